// File: doc/BRIEF.md
# Enhanced Parallel Port Host Engine

This block is the host end of an enhanced parallel port. A narrow I/O bus addresses eight byte registers: a plain output latch, a status byte, a control byte, an address register for selecting a peripheral register, and four data ports. A write to the address register, or an access to one of the data ports, starts an interlocked strobe cycle towards the peripheral. Address cycles use the address strobe and data cycles use the data strobe. The host bus cycle is held open through the ready output until the peripheral answers on its wait line.

All bus strobes are sampled on the block clock. An access begins on the clock edge that sees a bus strobe go low. Each byte of a wider transfer is a separate access to its own data port, so each byte has its own strobe cycle. The input `legacyMode` selects the older behaviour. In that mode, control bit 5 sets the transfer direction, and an access that goes against that direction stays inside the block. With `legacyMode` low, the kind of access alone picks the direction. A cycle-count timeout ends a cycle that the peripheral never acknowledges.

Top module: `epp_host_port`

## Requirements
- R1: After reset, `busRdy`, `writeN`, `addrStbN` and `dataStbN` are high and `pdOe` is low. Status (offset 1) reads 0x80 while `waitIn` is low, and control (offset 2) reads 0x20.
- R2: Offsets 0 (output latch) and 2 (control) read back the last value written to them. A write to status (offset 1) changes nothing.
- R3: A write to offset 3 latches the bus byte and drives it on `pdOut` with `pdOe` high. `writeN` goes low at least one cycle before `addrStbN` falls. `dataStbN` stays high during the cycle.
- R4: During a strobe cycle, `busRdy` is low only while `waitIn` is low, and it is released once `waitIn` rises. If `waitIn` is high for the whole cycle, `busRdy` never goes low.
- R5: Once the host strobe returns high, the active strobe and `writeN` return high. `pdOut` and `pdOe` do not change while a cycle strobe is low.
- R6: A write to offset 4+k (k = 0..3) produces exactly one `dataStbN` pulse, with that byte on `pdOut`, and no `addrStbN` pulse.
- R7: In a read cycle, `writeN` stays high and `pdOe` stays low. While the strobe is acknowledged, the bus returns live `pdIn`. That value is latched when the cycle ends and is returned by later register reads.
- R8: With `legacyMode` high and control bit 5 clear (forward), a read of offsets 3..7 produces no strobe and returns the latched value. With bit 5 set, such a read does produce a cycle.
- R9: With `legacyMode` high and control bit 5 set (reverse), a write to offsets 3..7 updates only the register and produces no strobe.
- R10: With `legacyMode` low, control bit 5 has no effect on transfers: a data-port read produces a read cycle even while bit 5 is clear.
- R11: If `waitIn` stays low for `TIMEOUT_CYC` cycles of a strobe cycle, the strobes are released, `busRdy` returns high and status bit 0 is set. The flag clears when the next strobe cycle starts.
- R12: While no cycle is running, `writeN`, `dataStbN` and `addrStbN` are the inverse of control bits 0, 1 and 3, and `initN` follows control bit 2. Status bit 7 reads 1 when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| legacyMode | input | 1 | 1 selects the older direction-gated behaviour |
| busAddr | input | 3 | Register offset |
| busWrData | input | 8 | Write data from the host |
| busRdData | output | 8 | Read data to the host |
| busWrN | input | 1 | Host write strobe, active low |
| busRdN | input | 1 | Host read strobe, active low |
| busRdy | output | 1 | Host cycle ready, low stretches the cycle |
| pdOut | output | 8 | Peripheral data out |
| pdOe | output | 1 | Peripheral data output enable |
| pdIn | input | 8 | Peripheral data in |
| writeN | output | 1 | Transfer direction to peripheral, low = write |
| addrStbN | output | 1 | Address strobe, active low |
| dataStbN | output | 1 | Data strobe, active low |
| initN | output | 1 | General control pin from control bit 2 |
| waitIn | input | 1 | Peripheral acknowledge, high = ready |

## Verification
The hardest case to reach from the ports is the peripheral that never answers. It needs a strobe held low with `waitIn` kept low for the full timeout window, while the host bus cycle is still open. The bench's peripheral responder can be switched off, and the host task keeps the bus strobe asserted until `busRdy` comes back. The run then shows the abort, the status flag, and the flag clearing on the next acknowledged cycle. The two-mode direction gating is reached by rewriting control bit 5 between accesses with `legacyMode` both set and clear.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

  localparam logic [2:0] OFS_LATCH  = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_ADDR   = 3'd3;

  localparam int NUM_PORTS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_END,
    ST_ABORT
  } cycState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       hostWr;      // store bus byte into hostAddr register
    logic [2:0] hostAddr;
    logic       capture;     // store pdIn into target register
    logic [2:0] target;      // register serviced by current cycle
    logic       clrTimeout;
    logic       setTimeout;
  } ctrlStb_t;

endpackage

// File: rtl/epp_host_ctrl.sv
module epp_host_ctrl
  import epp_host_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] busAddr,
  input  logic       busWrN,
  input  logic       busRdN,
  input  logic       waitIn,
  input  logic       legacyMode,
  input  logic       dirRev,
  output ctrlStb_t   stb,
  output logic       cycBusy,
  output logic       cycWriteN,
  output logic       cycAddrStbN,
  output logic       cycDataStbN,
  output logic       cycDrive,
  output logic       liveRead,
  output logic       busRdy
);

  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(TIMEOUT_CYC - 1);

  cycState_e state, stateNext;
  logic wrQ, rdQ;
  logic isRead;
  logic [2:0] targetQ;
  logic [TW-1:0] timer;

  logic eppReg, wrFall, rdFall, startWr, startRd, hostRel, strobeLow, timedOut;

  assign eppReg  = (busAddr == OFS_ADDR) || busAddr[2];
  assign wrFall  = wrQ && !busWrN;
  assign rdFall  = rdQ && !busRdN;
  assign startWr = (state == ST_IDLE) && wrFall && eppReg && !(legacyMode && dirRev);
  assign startRd = (state == ST_IDLE) && rdFall && eppReg && !(legacyMode && !dirRev);
  assign hostRel = isRead ? busRdN : busWrN;
  assign timedOut = (state == ST_STROBE) && !waitIn && (timer == LAST_TICK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrQ <= 1'b1;
      rdQ <= 1'b1;
    end else begin
      wrQ <= busWrN;
      rdQ <= busRdN;
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (startWr || startRd) stateNext = ST_SETUP;
      ST_SETUP:  stateNext = ST_STROBE;
      ST_STROBE: begin
        if (waitIn)        stateNext = ST_HOLD;
        else if (timedOut) stateNext = ST_ABORT;
      end
      ST_HOLD:   if (hostRel) stateNext = ST_END;
      ST_END:    stateNext = ST_IDLE;
      ST_ABORT:  if (hostRel) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isRead  <= 1'b0;
      targetQ <= OFS_ADDR;
      timer   <= '0;
    end else begin
      state <= stateNext;
      if (startWr || startRd) begin
        isRead  <= startRd;
        targetQ <= busAddr;
        timer   <= '0;
      end else if ((state == ST_SETUP || state == ST_STROBE) && timer != LAST_TICK) begin
        timer <= timer + 1'b1;
      end
    end
  end

  always_comb begin
    stb.hostWr     = (state == ST_IDLE) && wrFall;
    stb.hostAddr   = busAddr;
    stb.capture    = (state == ST_HOLD) && isRead && hostRel;
    stb.target     = targetQ;
    stb.clrTimeout = startWr || startRd;
    stb.setTimeout = timedOut;
  end

  assign strobeLow   = (state == ST_STROBE) || (state == ST_HOLD);
  assign cycBusy     = (state != ST_IDLE);
  assign cycWriteN   = !(!isRead && (state == ST_SETUP || strobeLow));
  assign cycAddrStbN = !(strobeLow && targetQ == OFS_ADDR);
  assign cycDataStbN = !(strobeLow && targetQ != OFS_ADDR);
  assign cycDrive    = !isRead;
  assign liveRead    = (state == ST_HOLD) && isRead;
  assign busRdy      = !((state == ST_SETUP || state == ST_STROBE) && !waitIn);

  AST_ABORT_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stb.setTimeout |=> (busRdy && cycAddrStbN && cycDataStbN)); // R11

  AST_LEGACY_FWD_READ_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rdFall && eppReg && legacyMode && !dirRev) |=> (state == ST_IDLE)); // R8

endmodule

// File: rtl/epp_host_dpath.sv
module epp_host_dpath
  import epp_host_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStb_t   stb,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWrData,
  input  logic [7:0] pdIn,
  input  logic       waitIn,
  input  logic       cycBusy,
  input  logic       cycWriteN,
  input  logic       cycAddrStbN,
  input  logic       cycDataStbN,
  input  logic       cycDrive,
  input  logic       liveRead,
  output logic [7:0] busRdData,
  output logic [7:0] pdOut,
  output logic       pdOe,
  output logic       writeN,
  output logic       addrStbN,
  output logic       dataStbN,
  output logic       initN,
  output logic       dirRev
);

  localparam logic [7:0] CTRL_RESET = 8'h20;

  logic [7:0] latchReg, ctrlReg, addrReg;
  logic [7:0] portReg [NUM_PORTS];
  logic       toFlag;
  logic [7:0] statusByte, tgtVal, regView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
      ctrlReg  <= CTRL_RESET;
      addrReg  <= '0;
    end else begin
      if (stb.hostWr && stb.hostAddr == OFS_LATCH) latchReg <= busWrData;
      if (stb.hostWr && stb.hostAddr == OFS_CTRL)  ctrlReg  <= busWrData;
      if (stb.hostWr && stb.hostAddr == OFS_ADDR)  addrReg  <= busWrData;
      else if (stb.capture && stb.target == OFS_ADDR) addrReg <= pdIn;
    end
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    localparam logic [2:0] MY_OFS = 3'(4 + g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  portReg[g] <= '0;
      else if (stb.hostWr && stb.hostAddr == MY_OFS) portReg[g] <= busWrData;
      else if (stb.capture && stb.target == MY_OFS)  portReg[g] <= pdIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               toFlag <= 1'b0;
    else if (stb.setTimeout) toFlag <= 1'b1;
    else if (stb.clrTimeout) toFlag <= 1'b0;
  end

  assign statusByte = {!cycBusy, waitIn, 5'b0, toFlag};
  assign tgtVal = (stb.target == OFS_ADDR) ? addrReg : portReg[stb.target[1:0]];

  always_comb begin
    case (busAddr)
      OFS_LATCH:  regView = latchReg;
      OFS_STATUS: regView = statusByte;
      OFS_CTRL:   regView = ctrlReg;
      OFS_ADDR:   regView = addrReg;
      default:    regView = portReg[busAddr[1:0]];
    endcase
  end

  assign busRdData = (liveRead && busAddr == stb.target) ? pdIn : regView;

  assign pdOut    = cycBusy ? tgtVal      : latchReg;
  assign pdOe     = cycBusy ? cycDrive    : !ctrlReg[5];
  assign writeN   = cycBusy ? cycWriteN   : !ctrlReg[0];
  assign dataStbN = cycBusy ? cycDataStbN : !ctrlReg[1];
  assign addrStbN = cycBusy ? cycAddrStbN : !ctrlReg[3];
  assign initN    = ctrlReg[2];
  assign dirRev   = ctrlReg[5];

  AST_CAPTURE_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (cycWriteN && !cycDrive)); // R7

endmodule

// File: rtl/epp_host_port.sv
module epp_host_port
  import epp_host_pkg::*;
#(
  parameter int TIMEOUT_CYC = 500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       legacyMode,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic       busWrN,
  input  logic       busRdN,
  output logic       busRdy,
  output logic [7:0] pdOut,
  output logic       pdOe,
  input  logic [7:0] pdIn,
  output logic       writeN,
  output logic       addrStbN,
  output logic       dataStbN,
  output logic       initN,
  input  logic       waitIn
);

  ctrlStb_t stb;
  logic cycBusy, cycWriteN, cycAddrStbN, cycDataStbN, cycDrive, liveRead, dirRev;

  epp_host_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrN(busWrN), .busRdN(busRdN),
    .waitIn(waitIn), .legacyMode(legacyMode), .dirRev(dirRev), .stb(stb),
    .cycBusy(cycBusy), .cycWriteN(cycWriteN), .cycAddrStbN(cycAddrStbN),
    .cycDataStbN(cycDataStbN), .cycDrive(cycDrive), .liveRead(liveRead), .busRdy(busRdy)
  );

  epp_host_dpath dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busWrData(busWrData),
    .pdIn(pdIn), .waitIn(waitIn), .cycBusy(cycBusy), .cycWriteN(cycWriteN),
    .cycAddrStbN(cycAddrStbN), .cycDataStbN(cycDataStbN), .cycDrive(cycDrive),
    .liveRead(liveRead), .busRdData(busRdData), .pdOut(pdOut), .pdOe(pdOe),
    .writeN(writeN), .addrStbN(addrStbN), .dataStbN(dataStbN), .initN(initN),
    .dirRev(dirRev)
  );

  AST_RDY_LOW_NEEDS_WAIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busRdy |-> !waitIn); // R4

  AST_PD_STABLE_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (cycBusy && !(addrStbN && dataStbN) && $past(cycBusy && !(addrStbN && dataStbN)))
      |-> ($stable(pdOut) && $stable(pdOe))); // R5

  AST_WRITE_SETTLED_BEFORE_ASTB: assert property (@(posedge clk) disable iff (!rstN)
    (cycBusy && $fell(addrStbN)) |-> $stable(writeN)); // R3

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (cycBusy && !dataStbN && writeN) |-> !pdOe); // R7

endmodule

// File: tb/epp_host_port_tb.sv
module epp_host_port_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       legacyMode = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       busWrN = 1'b1;
  logic       busRdN = 1'b1;
  logic       busRdy;
  logic [7:0] pdOut;
  logic       pdOe;
  logic [7:0] pdIn = 8'h00;
  logic       writeN, addrStbN, dataStbN, initN;
  logic       waitIn = 1'b0;

  int passCnt = 0;
  int totalCnt = 0;

  // peripheral responder controls
  bit respOn = 1'b1;
  bit idleWait = 1'b0;
  int respDelay = 3;
  int respCnt = 0;

  always #10 clk = ~clk;

  epp_host_port dut_i (
    .clk(clk), .rstN(rstN), .legacyMode(legacyMode), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busWrN(busWrN), .busRdN(busRdN),
    .busRdy(busRdy), .pdOut(pdOut), .pdOe(pdOe), .pdIn(pdIn), .writeN(writeN),
    .addrStbN(addrStbN), .dataStbN(dataStbN), .initN(initN), .waitIn(waitIn)
  );

  always @(negedge clk) begin
    if (!addrStbN || !dataStbN) begin
      if (respOn) begin
        respCnt++;
        if (respCnt >= respDelay) waitIn = 1'b1;
      end
    end else begin
      respCnt = 0;
      waitIn = idleWait;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
  endtask

  // one host bus access, with observation of the peripheral side
  task automatic busAccess(input bit wr, input logic [2:0] a, input logic [7:0] d,
                           output logic [7:0] rd, output bit rdyLow, output int aCnt,
                           output int dCnt, output logic [7:0] pdSeen, output bit wrLowAtStb,
                           output bit oeAtStb, output bit setupOk);
    bit pA, pD, pW;
    rd = '0; rdyLow = 0; aCnt = 0; dCnt = 0; pdSeen = '0;
    wrLowAtStb = 0; oeAtStb = 0; setupOk = 0;
    @(negedge clk);
    busAddr = a; busWrData = d;
    if (wr) busWrN = 1'b0; else busRdN = 1'b0;
    pA = 1; pD = 1; pW = 1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busRdy) rdyLow = 1;
      if (pA && !addrStbN) begin aCnt++; setupOk = !pW; end
      if (pD && !dataStbN) dCnt++;
      if (!addrStbN || !dataStbN) begin
        pdSeen = pdOut; wrLowAtStb = !writeN; oeAtStb = pdOe;
      end
      pA = addrStbN; pD = dataStbN; pW = writeN;
      if (i >= 8 && busRdy) begin rd = busRdData; break; end
    end
    busWrN = 1'b1; busRdN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (pA && !addrStbN) aCnt++;
      if (pD && !dataStbN) dCnt++;
      pA = addrStbN; pD = dataStbN;
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r; bit b1, b2, b3, b4; int c1, c2; logic [7:0] p;
    busAccess(1, a, d, r, b1, c1, c2, p, b2, b3, b4);
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] r);
    bit b1, b2, b3, b4; int c1, c2; logic [7:0] p;
    busAccess(0, a, 8'h00, r, b1, c1, c2, p, b2, b3, b4);
  endtask

  task automatic testReset();
    logic [7:0] r;
    @(negedge clk);
    check(busRdy && writeN && addrStbN && dataStbN, "R1 strobes/ready high",
          {busRdy, writeN, addrStbN, dataStbN}, 4'hF);
    check(!pdOe, "R1 pd released", pdOe, 0);
    regRead(3'd1, r); check(r == 8'h80, "R1 status", r, 8'h80);
    regRead(3'd2, r); check(r == 8'h20, "R1 control", r, 8'h20);
  endtask

  task automatic testRegs();
    logic [7:0] r;
    regWrite(3'd0, 8'h3C); regRead(3'd0, r); check(r == 8'h3C, "R2 latch readback", r, 8'h3C);
    regWrite(3'd2, 8'h24); regRead(3'd2, r); check(r == 8'h24, "R2 control readback", r, 8'h24);
    regWrite(3'd2, 8'h20);
    regWrite(3'd1, 8'hFF); regRead(3'd1, r); check(r == 8'h80, "R2 status ignores write", r, 8'h80);
  endtask

  task automatic testIdlePins();
    regWrite(3'd2, 8'h2F);
    @(negedge clk);
    check(!writeN && !dataStbN && !addrStbN && initN, "R12 idle pins follow control",
          {writeN, dataStbN, addrStbN, initN}, 4'b0001);
    regWrite(3'd2, 8'h20);
    @(negedge clk);
    check(writeN && dataStbN && addrStbN && !initN, "R12 idle pins after restore",
          {writeN, dataStbN, addrStbN, initN}, 4'b1110);
  endtask

  task automatic testAddrWrite();
    logic [7:0] r, p; bit rl, wl, oe, su; int ac, dc;
    busAccess(1, 3'd3, 8'hA5, r, rl, ac, dc, p, wl, oe, su);
    check(ac == 1 && dc == 0, "R3 one address strobe only", {ac[3:0], dc[3:0]}, 8'h10);
    check(p == 8'hA5 && oe, "R3 address byte driven", {oe, p}, 9'h1A5);
    check(wl && su, "R3 write low before strobe", {wl, su}, 2'b11);
    check(rl, "R4 ready held low while wait low", rl, 1);
    check(writeN && addrStbN, "R5 released after host strobe", {writeN, addrStbN}, 2'b11);
    regRead(3'd1, r); check(r[7] == 1'b1, "R12 idle status bit", r[7], 1);
  endtask

  task automatic testWaitHigh();
    logic [7:0] r, p; bit rl, wl, oe, su; int ac, dc;
    idleWait = 1'b1;
    busAccess(1, 3'd4, 8'h11, r, rl, ac, dc, p, wl, oe, su);
    idleWait = 1'b0;
    check(!rl && dc == 1, "R4 ready never low with wait high", {rl, dc[3:0]}, 5'h01);
  endtask

  task automatic testDataWrites();
    logic [7:0] r, p; bit rl, wl, oe, su; int ac, dc;
    for (int k = 0; k < 4; k++) begin
      busAccess(1, 3'(4 + k), 8'(8'h40 + k), r, rl, ac, dc, p, wl, oe, su);
      check(dc == 1 && ac == 0, "R6 one data strobe per byte", {ac[3:0], dc[3:0]}, 8'h01);
      check(p == 8'(8'h40 + k) && wl, "R6 byte on pd", p, 8'h40 + k);
      check(dataStbN && writeN, "R5 data strobe released", {dataStbN, writeN}, 2'b11);
    end
  endtask

  task automatic testReadCycles();
    logic [7:0] r, p; bit rl, wl, oe, su; int ac, dc;
    legacyMode = 1'b0;
    regWrite(3'd2, 8'h00);
    pdIn = 8'hC3;
    busAccess(0, 3'd6, 8'h00, r, rl, ac, dc, p, wl, oe, su);
    check(dc == 1, "R10 read cycle despite bit5 clear", dc, 1);
    check(r == 8'hC3, "R7 live pd returned", r, 8'hC3);
    check(!wl && !oe, "R7 write high and pd released", {wl, oe}, 2'b00);
    legacyMode = 1'b1;
    busAccess(0, 3'd6, 8'h00, r, rl, ac, dc, p, wl, oe, su);
    check(dc == 0 && ac == 0, "R8 forward read makes no strobe", dc, 0);
    check(r == 8'hC3, "R7 latched value returned", r, 8'hC3);
  endtask

  task automatic testLegacyWrite();
    logic [7:0] r, p; bit rl, wl, oe, su; int ac, dc;
    legacyMode = 1'b1;
    regWrite(3'd2, 8'h20);
    busAccess(1, 3'd5, 8'h33, r, rl, ac, dc, p, wl, oe, su);
    check(dc == 0 && ac == 0, "R9 reverse write makes no strobe", dc, 0);
    regWrite(3'd2, 8'h00);
    busAccess(0, 3'd5, 8'h00, r, rl, ac, dc, p, wl, oe, su);
    check(r == 8'h33, "R9 register updated", r, 8'h33);
    regWrite(3'd2, 8'h20);
    pdIn = 8'h5E;
    busAccess(0, 3'd5, 8'h00, r, rl, ac, dc, p, wl, oe, su);
    check(dc == 1 && r == 8'h5E, "R8 reverse read makes cycle", {dc[3:0], r}, 12'h15E);
    legacyMode = 1'b0;
  endtask

  task automatic testTimeout();
    logic [7:0] r, p; bit rl, wl, oe, su; int ac, dc;
    respOn = 1'b0;
    busAccess(1, 3'd4, 8'h99, r, rl, ac, dc, p, wl, oe, su);
    respOn = 1'b1;
    check(rl && busRdy, "R11 ready released after timeout", {rl, busRdy}, 2'b11);
    check(dataStbN && writeN, "R11 strobes released", {dataStbN, writeN}, 2'b11);
    regRead(3'd1, r); check(r == 8'h81, "R11 timeout flag", r, 8'h81);
    regWrite(3'd4, 8'h77);
    regRead(3'd1, r); check(r == 8'h80, "R11 flag cleared by next cycle", r, 8'h80);
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testIdlePins();
    testAddrWrite();
    testWaitHigh();
    testDataWrites();
    testReadCycles();
    testLegacyWrite();
    testTimeout();
    finished = 1;
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", passCnt, totalCnt);
      $finish;
    end
  end

endmodule